// File: doc/BRIEF.md
# Programmable Product-Term Sequencer Array

This block holds the combinational next-state logic of a field-programmable Mealy sequencer. Sixteen external inputs and eight present-state bits drive a plane of 64 programmable product terms. A programmable OR matrix then connects any mix of those terms to the J and K inputs of sixteen flip-flops. Eight of the flip-flops are state registers and eight are output registers. The flip-flops live outside this block.

Two single-term NOR arrays, called complement arrays, feed back into the product plane. Each one goes high only when none of its member terms is active. A term can then test "none of the listed conditions holds" with one literal, which gives an else branch or a catch for an illegal state. The fuse map is written one word per term through an address/data/write-enable port. A rule checker flags three illegal programs: a term that uses the input shared with the second clock while that option is on, a term that toggles too many registers, and a complement loop.

Top module: `seq_term_array`

## Requirements
- R1: While reset is low, every configuration word is cleared to all zeros. After reset, every term is inactive and `j_vec` and `k_vec` are zero for any inputs.
- R2: Each literal is a 2-bit code. Code 01 passes when the signal is 1, code 10 passes when the signal is 0, and code 11 always passes. A term is active when every one of its literals passes.
- R3: Literal code 00 (inactive) never passes. Any term that holds a 00 literal is forced to 0 whatever its other literals are.
- R4: `j_vec[r]` is the OR of all active terms whose J bit r is set, and `k_vec[r]` is the same for K bit r. One term may drive any number of J and K bits. Bits 0..7 belong to the state registers and bits 8..15 to the output registers.
- R5: Complement output n is 1 exactly when none of its member terms has its input/state literals all passing. With no members, the output is 1.
- R6: Complement outputs C0 and C1 are literals of every term. They use the R2 encoding and are evaluated after the complement arrays settle.
- R7: A configuration word is stored at the rising clock edge while `cfg_we` is high. Its layout from LSB is as follows. Bits [47:0] hold 24 literals: literal i sits at bits [2i+1:2i], literals 0..15 are the inputs and literals 16..23 are the state bits. Bits [51:48] hold the C0 literal and then the C1 literal. Bits [53:52] are the membership bits for C0 and C1. Bits [69:54] are the J connections and bits [85:70] are the K connections. While `cfg_we` is low, the port has no effect.
- R8: `err_clk2` is high when `dual_clk` is high and any of the 64 terms has an input-5 literal other than 11.
- R9: `err_toggle` is high when some term has both its J and K bit set for more than 8 registers.
- R10: `err_loop` is high when a term is a member of any complement array and has a complement literal other than 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Term index to write |
| cfg_data | input | 86 | Configuration word for one term |
| dual_clk | input | 1 | Second clock option selected |
| ext_in | input | 16 | External inputs |
| state_fb | input | 8 | Present-state feedback |
| j_vec | output | 16 | J inputs of the 16 registers |
| k_vec | output | 16 | K inputs of the 16 registers |
| err_clk2 | output | 1 | Input 5 used while the second clock option is on |
| err_toggle | output | 1 | Toggle fan-out limit exceeded |
| err_loop | output | 1 | Complement member also uses a complement literal |

## Verification
The bench targets three corner cases of the complement path.

- **Complement array with no members.** The output must be a constant 1. A design that inverted the sense would make every term using that literal dead.
- **Member term that goes inactive.** When its member term drops, the complement output must go high. A design that ORed the full terms rather than their input/state products would not settle.
- **00 code on an otherwise passing term.** This code must kill the term. A design that treated 00 as don't-care would light extra J bits.

The rule checks are driven on both sides of each limit. The toggle check uses exactly 8 and then 9 registers. The input-5 check runs with all terms clean and then with one term using input 5. A write attempted with the enable low must leave the outputs unchanged.

// File: rtl/seq_pkg.sv
// Shared sizes, the per-term configuration word and the literal decode.
// Assumes one flat word per term; all widths derive from the counts below.
package seq_pkg;
    parameter int N_IN       = 16;
    parameter int N_ST       = 8;
    parameter int N_TERM     = 64;
    parameter int N_REG      = 16;
    parameter int N_CMP      = 2;
    parameter int TOGGLE_MAX = 8;
    parameter int CLK2_IDX   = 5;

    localparam int N_LIT  = N_IN + N_ST;
    localparam int ADDR_W = $clog2(N_TERM);
    localparam int WORD_W = 2*N_LIT + 2*N_CMP + N_CMP + 2*N_REG;

    typedef struct packed {
        logic [N_REG-1:0]   k_con;
        logic [N_REG-1:0]   j_con;
        logic [N_CMP-1:0]   member;
        logic [2*N_CMP-1:0] c_lit;
        logic [2*N_LIT-1:0] lit;
    } term_cfg_t;

    // bit0 allows a high signal, bit1 allows a low one; 00 blocks both
    function automatic logic lit_pass(logic [1:0] code, logic v);
        return v ? code[0] : code[1];
    endfunction
endpackage

// File: rtl/seq_cfg_store.sv
// Configuration register file: one word per product term.
// Assumes writes are single-cycle; reset clears every word (all terms inactive).
module seq_cfg_store
    import seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [WORD_W-1:0]      wdata,
    output term_cfg_t              cfg_q [N_TERM]
);
    term_cfg_t mem [N_TERM];

    // store the addressed word, or clear all on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) mem[t] <= '0;
        end else if (we) begin
            mem[addr] <= term_cfg_t'(wdata);
        end
    end

    // expose stored words to the planes
    always_comb begin
        for (int t = 0; t < N_TERM; t++) cfg_q[t] = mem[t];
    end
endmodule

// File: rtl/seq_term_plane.sv
// AND plane, complement (NOR) arrays and OR matrix.
// Assumes member terms keep complement literals don't-care (checked elsewhere),
// so complement arrays take only the input/state product and no loop exists.
module seq_term_plane
    import seq_pkg::*;
(
    input  term_cfg_t          cfg [N_TERM],
    input  logic [N_IN-1:0]    ext_in,
    input  logic [N_ST-1:0]    state_fb,
    output logic [N_TERM-1:0]  term_base,
    output logic [N_TERM-1:0]  term_full,
    output logic [N_CMP-1:0]   cmp_out,
    output logic [N_REG-1:0]   j_vec,
    output logic [N_REG-1:0]   k_vec
);
    logic [N_LIT-1:0] lit_v;
    assign lit_v = {state_fb, ext_in};

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic base_b;
        logic cmp_b;
        // product of the input and state literals
        always_comb begin
            base_b = 1'b1;
            for (int l = 0; l < N_LIT; l++)
                base_b &= lit_pass(cfg[t].lit[2*l +: 2], lit_v[l]);
        end
        // product of the complement literals
        always_comb begin
            cmp_b = 1'b1;
            for (int n = 0; n < N_CMP; n++)
                cmp_b &= lit_pass(cfg[t].c_lit[2*n +: 2], cmp_out[n]);
        end
        assign term_base[t] = base_b;
        assign term_full[t] = base_b & cmp_b;
    end

    for (genvar n = 0; n < N_CMP; n++) begin : g_cmp
        logic [N_TERM-1:0] mask;
        // collect the terms enrolled in this complement array
        always_comb begin
            for (int t = 0; t < N_TERM; t++) mask[t] = cfg[t].member[n];
        end
        assign cmp_out[n] = ~|(term_base & mask);
    end

    // OR matrix onto J and K inputs
    always_comb begin
        j_vec = '0;
        k_vec = '0;
        for (int r = 0; r < N_REG; r++) begin
            for (int t = 0; t < N_TERM; t++) begin
                j_vec[r] |= term_full[t] & cfg[t].j_con[r];
                k_vec[r] |= term_full[t] & cfg[t].k_con[r];
            end
        end
    end
endmodule

// File: rtl/seq_cfg_rules.sv
// Configuration rule checker: second-clock input use, toggle fan-out, loops.
// Assumes it sees the live stored words; flags are purely combinational.
module seq_cfg_rules
    import seq_pkg::*;
(
    input  term_cfg_t  cfg [N_TERM],
    input  logic       dual_clk,
    output logic       err_clk2,
    output logic       err_toggle,
    output logic       err_loop
);
    // any term touching the input shared with the second clock
    always_comb begin
        err_clk2 = 1'b0;
        for (int t = 0; t < N_TERM; t++)
            if (cfg[t].lit[2*CLK2_IDX +: 2] != 2'b11) err_clk2 = dual_clk;
    end

    // any term toggling more than the allowed register count
    always_comb begin
        err_toggle = 1'b0;
        for (int t = 0; t < N_TERM; t++)
            if ($countones(cfg[t].j_con & cfg[t].k_con) > TOGGLE_MAX)
                err_toggle = 1'b1;
    end

    // any complement member that also reads a complement output
    always_comb begin
        err_loop = 1'b0;
        for (int t = 0; t < N_TERM; t++)
            if ((|cfg[t].member) && (cfg[t].c_lit != {2*N_CMP{1'b1}}))
                err_loop = 1'b1;
    end
endmodule

// File: rtl/seq_term_array.sv
// Top: programmable product-term sequencer array.
// Assumes external J/K flip-flops consume j_vec/k_vec; only config is clocked.
module seq_term_array
    import seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [WORD_W-1:0]      cfg_data,
    input  logic                   dual_clk,
    input  logic [N_IN-1:0]        ext_in,
    input  logic [N_ST-1:0]        state_fb,
    output logic [N_REG-1:0]       j_vec,
    output logic [N_REG-1:0]       k_vec,
    output logic                   err_clk2,
    output logic                   err_toggle,
    output logic                   err_loop
);
    term_cfg_t          cfg_q [N_TERM];
    logic [N_TERM-1:0]  term_base;
    logic [N_TERM-1:0]  term_full;
    logic [N_CMP-1:0]   cmp_out;

    seq_cfg_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_data),
        .cfg_q (cfg_q)
    );

    seq_term_plane u_plane (
        .cfg       (cfg_q),
        .ext_in    (ext_in),
        .state_fb  (state_fb),
        .term_base (term_base),
        .term_full (term_full),
        .cmp_out   (cmp_out),
        .j_vec     (j_vec),
        .k_vec     (k_vec)
    );

    seq_cfg_rules u_rules (
        .cfg        (cfg_q),
        .dual_clk   (dual_clk),
        .err_clk2   (err_clk2),
        .err_toggle (err_toggle),
        .err_loop   (err_loop)
    );
endmodule

// File: rtl/seq_term_array_chk.sv
// Assertion checker for seq_term_array, attached by bind.
module seq_term_array_chk
    import seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               dual_clk,
    input  logic [N_IN-1:0]    ext_in,
    input  logic [N_ST-1:0]    state_fb,
    input  logic [N_REG-1:0]   j_vec,
    input  logic [N_REG-1:0]   k_vec,
    input  logic               err_clk2,
    input  logic [N_TERM-1:0]  term_base,
    input  logic [N_TERM-1:0]  term_full,
    input  logic [N_CMP-1:0]   cmp_out
);
    // R1: leaving reset, no J or K is driven
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (j_vec == '0 && k_vec == '0));

    // R7: no write and steady inputs keep outputs steady
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && $stable(ext_in) && $stable(state_fb))
            |-> ($stable(j_vec) && $stable(k_vec)));

    // R4: a driven J or K needs some active term
    a_r4_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
        (j_vec != '0 || k_vec != '0) |-> (term_full != '0));

    // R5: a low complement output needs an active input/state product
    a_r5_cmp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_out != {N_CMP{1'b1}}) |-> (term_base != '0));

    // R8: the second-clock flag stays low without the option
    a_r8_clk2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_clk |-> !err_clk2);
endmodule

bind seq_term_array seq_term_array_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .dual_clk  (dual_clk),
    .ext_in    (ext_in),
    .state_fb  (state_fb),
    .j_vec     (j_vec),
    .k_vec     (k_vec),
    .err_clk2  (err_clk2),
    .term_base (term_base),
    .term_full (term_full),
    .cmp_out   (cmp_out)
);

// File: tb/seq_term_array_test.sv
`timescale 1ns/1ps
module seq_term_array_test;
    import seq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [WORD_W-1:0] cfg_data = '0;
    logic              dual_clk = 1'b1;
    logic [15:0]       ext_in = 16'hFFFF;
    logic [7:0]        state_fb = 8'hFF;
    logic [15:0]       j_vec, k_vec;
    logic              err_clk2, err_toggle, err_loop;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [47:0] DC = {48{1'b1}};

    seq_term_array uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .dual_clk(dual_clk), .ext_in(ext_in),
        .state_fb(state_fb), .j_vec(j_vec), .k_vec(k_vec),
        .err_clk2(err_clk2), .err_toggle(err_toggle), .err_loop(err_loop)
    );

    always #2.5 clk = ~clk;

    // stimulus {ext_in, state_fb} and expected {j_vec, k_vec}
    localparam logic [55:0] VECS [7] = '{
        {16'h0000, 8'h00, 16'h0012, 16'h0010},
        {16'h0001, 8'h00, 16'h8013, 16'h0010},
        {16'h0006, 8'h00, 16'h0114, 16'h0018},
        {16'h0002, 8'h01, 16'h0012, 16'h0010},
        {16'h0000, 8'h80, 16'h8012, 16'h0210},
        {16'h8000, 8'h80, 16'h0012, 16'h0010},
        {16'h0011, 8'h00, 16'h8013, 16'h0010}
    };

    function automatic logic [47:0] setlit(logic [47:0] w, int idx, logic [1:0] c);
        w[2*idx +: 2] = c;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] mk(logic [47:0] l, logic [3:0] c,
            logic [1:0] m, logic [15:0] j, logic [15:0] k);
        return {k, j, m, c, l};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_term(int a, logic [WORD_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = ADDR_W'(a);
        cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic apply(logic [15:0] ei, logic [7:0] st);
        @(negedge clk);
        ext_in = ei;
        state_fb = st;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state with all inputs high
        repeat (3) @(negedge clk);
        #1;
        check("R1", "j after reset", 32'(j_vec), 32'h0);
        check("R1", "k after reset", 32'(k_vec), 32'h0);
        // R8: unprogrammed terms hold 00 on input 5
        check("R8", "clk2 flag on blank map", 32'(err_clk2), 32'h1);
        check("R9", "toggle flag blank", 32'(err_toggle), 32'h0);
        check("R10", "loop flag blank", 32'(err_loop), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        dual_clk = 1'b0;
        #1;
        check("R8", "clk2 flag option off", 32'(err_clk2), 32'h0);

        // program the reference map (R7 layout)
        write_term(0, mk(setlit(DC, 0, 2'b01), 4'hF, 2'b00, 16'h0001, 16'h0000));
        write_term(1, mk(setlit(setlit(DC, 1, 2'b01), 16, 2'b10), 4'hF, 2'b00, 16'h0100, 16'h0008));
        write_term(2, mk(setlit(DC, 2, 2'b10), 4'hF, 2'b01, 16'h0002, 16'h0000));
        write_term(3, mk(DC, 4'b1101, 2'b00, 16'h0004, 16'h0000));
        write_term(4, mk(DC, 4'b0111, 2'b00, 16'h0010, 16'h0010));
        write_term(5, mk(setlit(DC, 4, 2'b00), 4'hF, 2'b00, 16'h0020, 16'h0000));
        write_term(6, mk(setlit(setlit(DC, 23, 2'b01), 15, 2'b10), 4'hF, 2'b00, 16'h8000, 16'h0200));
        write_term(7, mk(setlit(DC, 0, 2'b01), 4'hF, 2'b00, 16'h8000, 16'h0000));
        check("R10", "loop flag on legal map", 32'(err_loop), 32'h0);

        // R2 R3 R4 R5 R6: table walk
        for (int i = 0; i < 7; i++) begin
            apply(VECS[i][55:40], VECS[i][39:32]);
            check("R2/R4/R5/R6", $sformatf("j vec %0d", i), 32'(j_vec), 32'(VECS[i][31:16]));
            check("R3/R4/R5", $sformatf("k vec %0d", i), 32'(k_vec), 32'(VECS[i][15:0]));
        end

        // R7: write with enable low is ignored
        apply(16'h0001, 8'h00);
        @(negedge clk);
        cfg_addr = '0;
        cfg_data = mk(DC, 4'hF, 2'b00, 16'hFFFF, 16'hFFFF);
        @(negedge clk);
        #1;
        check("R7", "j after disabled write", 32'(j_vec), 32'h8013);
        check("R7", "k after disabled write", 32'(k_vec), 32'h0010);

        // R8: clean input 5 in all terms, then one offender
        for (int t = 8; t < 64; t++)
            write_term(t, mk(DC, 4'hF, 2'b00, 16'h0000, 16'h0000));
        dual_clk = 1'b1;
        #1;
        check("R8", "clk2 flag all clean", 32'(err_clk2), 32'h0);
        check("R4", "unconnected terms add nothing", 32'(j_vec), 32'h8013);
        write_term(0, mk(setlit(setlit(DC, 0, 2'b01), 5, 2'b01), 4'hF, 2'b00, 16'h0001, 16'h0000));
        check("R8", "clk2 flag input 5 used", 32'(err_clk2), 32'h1);
        write_term(0, mk(setlit(DC, 0, 2'b01), 4'hF, 2'b00, 16'h0001, 16'h0000));
        dual_clk = 1'b0;

        // R9: toggle limit at 8 and 9 registers
        apply(16'h0000, 8'h00);
        write_term(10, mk(DC, 4'hF, 2'b00, 16'h00FF, 16'h00FF));
        check("R9", "toggle 8 regs flag", 32'(err_toggle), 32'h0);
        check("R4", "toggle term on j", 32'(j_vec), 32'h00FF);
        check("R4", "toggle term on k", 32'(k_vec), 32'h00FF);
        write_term(10, mk(DC, 4'hF, 2'b00, 16'h01FF, 16'h01FF));
        check("R9", "toggle 9 regs flag", 32'(err_toggle), 32'h1);
        write_term(10, mk(DC, 4'hF, 2'b00, 16'h0000, 16'h0000));
        check("R9", "toggle flag cleared", 32'(err_toggle), 32'h0);

        // R10: member of C1 reading C1
        write_term(11, mk(DC, 4'b0111, 2'b10, 16'h0000, 16'h0000));
        check("R10", "loop flag raised", 32'(err_loop), 32'h1);
        write_term(11, mk(DC, 4'hF, 2'b00, 16'h0000, 16'h0000));
        check("R10", "loop flag cleared", 32'(err_loop), 32'h0);

        // R5: C0 member always active keeps C0 low, so term 3 stays off
        write_term(12, mk(DC, 4'hF, 2'b01, 16'h0000, 16'h0000));
        apply(16'h0004, 8'h00);
        check("R5", "C0 forced low by member", 32'(j_vec), 32'h0010);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule